// File: doc/BRIEF.md
# Paged Address Translation Unit

This block turns a 32-bit virtual address into a 15-bit physical address for a memory with eight page frames of 4 KB each. The upper twenty bits of a request name a virtual page and the lower twelve bits are the byte offset inside it. The page number indexes a small table of entries held in registers. Each entry is a resident flag plus a 3-bit frame number.

When the entry is resident, the frame number and the untouched offset form the physical address. If the entry is not resident, or the page number lies past the end of the table, the block reports a fault and records the offending page number. A separate write port installs or clears entries.

Responses come back one clock after the request. Replacement of pages and any transfer to backing storage belong to the surrounding system.

Top module: `page_xlate_unit`

## Requirements
- R1: After reset, rsp_valid_o, rsp_fault_o, rsp_paddr_o and fault_vpn_o are all zero and every table entry is non-resident, so the first request to any page faults.
- R2: A request whose page number is below 16 and whose entry is resident produces, in the next cycle, rsp_fault_o = 0 and rsp_paddr_o = {entry frame, vaddr[11:0]}, with the frame in bits [14:12].
- R3: A request whose page number is below 16 and whose entry is non-resident produces, in the next cycle, rsp_fault_o = 1 and rsp_paddr_o = 0.
- R4: A request whose page number (vaddr[31:12]) is 16 or more produces a fault in the next cycle, whatever entry vaddr[15:12] would select.
- R5: rsp_valid_o is 1 exactly in the cycle after a cycle with req_valid_i = 1. When rsp_valid_o is 0, rsp_fault_o and rsp_paddr_o are 0.
- R6: fault_vpn_o takes the page number of each faulting request in the cycle that the fault is reported. It holds that value through responses without a fault and through idle cycles.
- R7: A write with wr_en_i = 1 sets entry wr_idx_i to resident = wr_present_i and frame = wr_frame_i from the next cycle on.
- R8: A request issued in the same cycle as a write to its own entry uses the entry as it was before the write. The following request sees the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translate request strobe |
| req_vaddr_i | input | 32 | Virtual address to translate |
| wr_en_i | input | 1 | Table entry write strobe |
| wr_idx_i | input | 4 | Entry index to write |
| wr_present_i | input | 1 | Resident flag to store |
| wr_frame_i | input | 3 | Frame number to store |
| rsp_valid_o | output | 1 | Response strobe, one cycle after a request |
| rsp_fault_o | output | 1 | Response is a page fault |
| rsp_paddr_o | output | 15 | Physical address, zero on fault |
| fault_vpn_o | output | 20 | Page number of the most recent fault |

## Verification
The bench aims at page numbers just past the table, such as 16 and larger values whose low four bits alias a resident entry. A design that checks only the low index bits would return a physical address there instead of a fault. It also writes an entry in the same cycle as a request to that entry. A design that forwards the write would report the new frame one request too early. Random runs mix faults with hits and idle cycles, so a fault-page register that updates on every response, or that clears, is caught. Random offsets show any bit swapped between the frame and offset fields.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
  parameter int unsigned PXU_VA_W   = 32;
  parameter int unsigned PXU_OFF_W  = 12;
  parameter int unsigned PXU_FRM_W  = 3;
  parameter int unsigned PXU_DEPTH  = 16;

  typedef enum logic [1:0] {
    XL_HIT   = 2'd0,
    XL_MISS  = 2'd1,
    XL_RANGE = 2'd2
  } xl_kind_e;
endpackage

// File: rtl/pxu_table.sv
module pxu_table #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned FRM_W = 3,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_present_i,
  input  logic [FRM_W-1:0] wr_frame_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_present_o,
  output logic [FRM_W-1:0] rd_frame_o
);
  logic [DEPTH-1:0] present_q;
  logic [FRM_W-1:0] frame_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic hit;
    assign hit = wr_en_i && (wr_idx_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        present_q[g] <= 1'b0;
        frame_q[g]   <= '0;
      end else if (hit) begin
        present_q[g] <= wr_present_i;
        frame_q[g]   <= wr_frame_i;
      end
    end
  end

  // read sees pre-write contents
  assign rd_present_o = present_q[rd_idx_i];
  assign rd_frame_o   = frame_q[rd_idx_i];
endmodule

// File: rtl/pxu_lookup.sv
module pxu_lookup
  import pxu_pkg::*;
#(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned FRM_W = 3,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned VPN_W = VA_W - OFF_W,
  localparam int unsigned PA_W  = FRM_W + OFF_W
) (
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic             ent_present_i,
  input  logic [FRM_W-1:0] ent_frame_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [VPN_W-1:0] vpn_o,
  output xl_kind_e         kind_o,
  output logic [PA_W-1:0]  paddr_o
);
  logic [OFF_W-1:0] offset;
  logic             in_range;

  assign vpn_o    = vaddr_i[VA_W-1:OFF_W];
  assign offset   = vaddr_i[OFF_W-1:0];
  assign idx_o    = vpn_o[IDX_W-1:0];
  assign in_range = (vpn_o[VPN_W-1:IDX_W] == '0);

  always_comb begin
    if (!in_range)          kind_o = XL_RANGE;
    else if (!ent_present_i) kind_o = XL_MISS;
    else                    kind_o = XL_HIT;
  end

  assign paddr_o = (kind_o == XL_HIT) ? {ent_frame_i, offset} : '0;
endmodule

// File: rtl/pxu_resp_reg.sv
module pxu_resp_reg
  import pxu_pkg::*;
#(
  parameter int unsigned PA_W  = 15,
  parameter int unsigned VPN_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  xl_kind_e         kind_i,
  input  logic [PA_W-1:0]  paddr_i,
  input  logic [VPN_W-1:0] vpn_i,
  output logic             rsp_valid_o,
  output logic             rsp_fault_o,
  output logic [PA_W-1:0]  rsp_paddr_o,
  output logic [VPN_W-1:0] fault_vpn_o
);
  logic fault_d;
  assign fault_d = req_valid_i && (kind_i != XL_HIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_fault_o <= 1'b0;
      rsp_paddr_o <= '0;
      fault_vpn_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_fault_o <= fault_d;
      rsp_paddr_o <= req_valid_i ? paddr_i : '0;
      if (fault_d) fault_vpn_o <= vpn_i;
    end
  end
endmodule

// File: rtl/page_xlate_unit.sv
module page_xlate_unit
  import pxu_pkg::*;
#(
  parameter int unsigned VA_W  = PXU_VA_W,
  parameter int unsigned OFF_W = PXU_OFF_W,
  parameter int unsigned FRM_W = PXU_FRM_W,
  parameter int unsigned DEPTH = PXU_DEPTH,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned VPN_W = VA_W - OFF_W,
  localparam int unsigned PA_W  = FRM_W + OFF_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_present_i,
  input  logic [FRM_W-1:0] wr_frame_i,
  output logic             rsp_valid_o,
  output logic             rsp_fault_o,
  output logic [PA_W-1:0]  rsp_paddr_o,
  output logic [VPN_W-1:0] fault_vpn_o
);
  logic [IDX_W-1:0] rd_idx;
  logic             ent_present;
  logic [FRM_W-1:0] ent_frame;
  logic [VPN_W-1:0] vpn;
  xl_kind_e         kind;
  logic [PA_W-1:0]  paddr;

  pxu_table #(.DEPTH(DEPTH), .FRM_W(FRM_W)) u_table (
    .clk_i, .rst_ni, .wr_en_i, .wr_idx_i, .wr_present_i, .wr_frame_i,
    .rd_idx_i(rd_idx), .rd_present_o(ent_present), .rd_frame_o(ent_frame)
  );

  pxu_lookup #(.VA_W(VA_W), .OFF_W(OFF_W), .FRM_W(FRM_W), .DEPTH(DEPTH)) u_lookup (
    .vaddr_i(req_vaddr_i), .ent_present_i(ent_present), .ent_frame_i(ent_frame),
    .idx_o(rd_idx), .vpn_o(vpn), .kind_o(kind), .paddr_o(paddr)
  );

  pxu_resp_reg #(.PA_W(PA_W), .VPN_W(VPN_W)) u_resp (
    .clk_i, .rst_ni, .req_valid_i, .kind_i(kind), .paddr_i(paddr), .vpn_i(vpn),
    .rsp_valid_o, .rsp_fault_o, .rsp_paddr_o, .fault_vpn_o
  );
endmodule

// File: rtl/pxu_checker.sv
module pxu_checker #(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned FRM_W = 3,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned VPN_W = VA_W - OFF_W,
  localparam int unsigned PA_W  = FRM_W + OFF_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic [VA_W-1:0]  req_vaddr_i,
  input logic             rsp_valid_o,
  input logic             rsp_fault_o,
  input logic [PA_W-1:0]  rsp_paddr_o,
  input logic [VPN_W-1:0] fault_vpn_o
);
  AST_VALID_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o); // R5
  AST_IDLE_AFTER_NOREQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!rsp_valid_o && !rsp_fault_o && rsp_paddr_o == '0)); // R5
  AST_FAULT_ZERO_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o |-> (rsp_valid_o && rsp_paddr_o == '0)); // R3
  AST_RANGE_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_vaddr_i[VA_W-1:OFF_W+IDX_W] != '0) |=> rsp_fault_o); // R4
  AST_OFFSET_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (rsp_fault_o || rsp_paddr_o[OFF_W-1:0] == $past(req_vaddr_i[OFF_W-1:0]))); // R2
  AST_FAULT_VPN_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_vaddr_i[VA_W-1:OFF_W+IDX_W] != '0) |=> fault_vpn_o == $past(req_vaddr_i[VA_W-1:OFF_W])); // R6
  AST_FAULT_VPN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_fault_o |-> $stable(fault_vpn_o)); // R6
endmodule

bind page_xlate_unit pxu_checker #(
  .VA_W(VA_W), .OFF_W(OFF_W), .FRM_W(FRM_W), .DEPTH(DEPTH)
) u_chk (
  .clk_i, .rst_ni, .req_valid_i, .req_vaddr_i,
  .rsp_valid_o, .rsp_fault_o, .rsp_paddr_o, .fault_vpn_o
);

// File: tb/page_xlate_unit_tb.sv
`timescale 1ns/1ps
module page_xlate_unit_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_vaddr_i = '0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_idx_i = '0;
  logic        wr_present_i = 1'b0;
  logic [2:0]  wr_frame_i = '0;
  logic        rsp_valid_o, rsp_fault_o;
  logic [14:0] rsp_paddr_o;
  logic [19:0] fault_vpn_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done = 1'b0;

  logic       m_pres [16];
  logic [2:0] m_frm  [16];
  logic [19:0] m_fvpn;

  always #2 clk = ~clk;

  page_xlate_unit u_dut (
    .clk_i(clk), .rst_ni, .req_valid_i, .req_vaddr_i, .wr_en_i, .wr_idx_i,
    .wr_present_i, .wr_frame_i, .rsp_valid_o, .rsp_fault_o, .rsp_paddr_o, .fault_vpn_o
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_fault(input logic [31:0] va);
    return (va[31:16] != 0) || !m_pres[va[15:12]];
  endfunction

  function automatic logic [14:0] exp_paddr(input logic [31:0] va);
    return exp_fault(va) ? 15'd0 : {m_frm[va[15:12]], va[11:0]};
  endfunction

  // one cycle: drive at negedge, check results at the following negedge
  task automatic step(input logic rq, input logic [31:0] va, input logic we,
                      input logic [3:0] wi, input logic wp, input logic [2:0] wf,
                      input string tag);
    logic ef;
    logic [14:0] ep;
    req_valid_i = rq; req_vaddr_i = va;
    wr_en_i = we; wr_idx_i = wi; wr_present_i = wp; wr_frame_i = wf;
    ef = rq && exp_fault(va);
    ep = rq ? exp_paddr(va) : 15'd0;
    if (ef) m_fvpn = va[31:12];
    if (we) begin m_pres[wi] = wp; m_frm[wi] = wf; end
    @(negedge clk);
    check({tag, "/R5 valid"}, 32'(rsp_valid_o), 32'(rq));
    if (rq) begin
      check({tag, " fault"}, 32'(rsp_fault_o), 32'(ef));
      check({tag, " paddr"}, 32'(rsp_paddr_o), 32'(ep));
    end
    check({tag, "/R6 fault_vpn"}, 32'(fault_vpn_o), 32'(m_fvpn));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) begin m_pres[i] = 1'b0; m_frm[i] = '0; end
    m_fvpn = '0;
    repeat (3) @(negedge clk);
    // R1 reset outputs
    check("R1 valid", 32'(rsp_valid_o), 0);
    check("R1 fault", 32'(rsp_fault_o), 0);
    check("R1 paddr", 32'(rsp_paddr_o), 0);
    check("R1 fault_vpn", 32'(fault_vpn_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 first accesses fault
    step(1, 32'h0000_3abc, 0, 0, 0, 0, "R1");
    step(1, 32'h0000_f001, 0, 0, 0, 0, "R1");
    // R7 install entries
    step(0, 0, 1, 4'd3, 1, 3'd6, "R7");
    step(0, 0, 1, 4'd0, 1, 3'd1, "R7");
    step(1, 32'h0000_3123, 0, 0, 0, 0, "R2");
    step(1, 32'h0000_0fff, 0, 0, 0, 0, "R2");
    // R4 out-of-range aliasing a resident entry
    step(1, 32'h0001_0000, 0, 0, 0, 0, "R4");
    step(1, 32'h0001_3456, 0, 0, 0, 0, "R4");
    step(1, 32'hffff_f123, 0, 0, 0, 0, "R4");
    step(0, 0, 0, 0, 0, 0, "R6 idle");
    step(1, 32'h0000_3555, 0, 0, 0, 0, "R6 hold");
    // R8 same-cycle write: old entry used, then new
    step(1, 32'h0000_3777, 1, 4'd3, 1, 3'd2, "R8 old");
    step(1, 32'h0000_3777, 0, 0, 0, 0, "R8 new");
    step(1, 32'h0000_5000, 1, 4'd5, 1, 3'd7, "R8 old miss");
    step(1, 32'h0000_5000, 1, 4'd5, 0, 3'd0, "R8 new hit");
    step(1, 32'h0000_5000, 0, 0, 0, 0, "R3 invalidated");
    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [31:0] va;
      logic rq, we;
      rq = ($urandom % 4) != 0;
      we = ($urandom % 3) == 0;
      va = {12'd0, 4'($urandom), 12'($urandom)};
      if (($urandom % 8) == 0) va = $urandom | 32'h0001_0000;
      step(rq, va, we, 4'($urandom), 1'($urandom), 3'($urandom), "R2/R3/R4/R7 rand");
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule